// File: doc/BRIEF.md
# Watchdog Counter with Selectable Tick

This block is an 8-bit up-counting watchdog. Each time its selected tick enable fires, the count goes up by one. When the count rolls over from 0xFF to 0x00, the block raises a one-cycle internal reset request and latches a sticky status bit. Software must reload the counter often enough to keep it from rolling over.

The tick comes from one of two places. The first is a free-running system-clock prescaler, which offers ten taps chosen by a 4-bit clock-select field. The second is an external enable input that already carries the subclock divided by 32. An override input forces the subclock tick whatever the select field holds. The block sits on a small register bus with an address, a write strobe, write data and combinational read data. All logic runs on one clock with a synchronous active-high reset.

Top module: `wdt_top`

## Requirements
- R1: After reset the counter reads 0x00, the mode register reads 0xFF, the status register reads 0x00 and `wdt_rst_o` is low.
- R2: When the selected tick fires and no counter write takes place, the counter increases by exactly one. With no tick it holds its value.
- R3: When a tick arrives while the counter holds 0xFF, the counter becomes 0x00 at that edge and `wdt_rst_o` is high for exactly the following cycle.
- R4: The status flag (bit 0 at address 2) is set by a rollover and stays set. A write of bit 0 = 0 to address 2 clears it, and a write of bit 0 = 1 has no effect. A rollover in the same cycle as a clear leaves the flag set.
- R5: A write to address 1 stores data bits 3:0 as the clock-select field. Bits 7:4 at that address always read as 1, and writes to them are ignored.
- R6: Select codes 0 to 9 pick the system clock divided by 2, 4, 8, 16, 32, 64, 128, 256, 512 and 8192. The tap for 2^k fires in the cycle in which the number of clock cycles since reset, plus one, is a multiple of 2^k.
- R7: Select codes 10 to 15, including the reset value 15, make `sub_tick_i` the tick.
- R8: While `sel_override_i` is 1, `sub_tick_i` is the tick whatever the select field holds.
- R9: A write to address 0 loads the counter and wins over a tick in the same cycle. Such a write never causes a reset pulse, even when the counter held 0xFF.
- R10: Read data is combinational from `addr_i`: address 0 gives the counter, 1 gives the mode register, 2 gives {7'b0, flag}, and 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| sel_override_i | input | 1 | Forces the subclock tick |
| sub_tick_i | input | 1 | Single-cycle enable carrying subclock/32, already synchronised |
| wdt_rst_o | output | 1 | One-cycle internal reset request on rollover |

## Verification
The counter is driven under each of the ten prescaler codes, under a reserved code and under the override. This shows whether the right tap is routed and whether the divider phases line up with the count of cycles since reset. The slow divide-by-8192 code is run long enough to see two ticks, which separates it from the 512 tap. Rollovers are provoked both by ticking up from near 0xFF and by repeated reloads of 0xFF. This tells a rollover tick apart from a software write. Status clears are issued on every cycle around a rollover, so the set-over-clear priority is exercised at the exact colliding edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W    = 8;
    localparam int SEL_W    = 4;
    localparam int NUM_TAPS = 10;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam logic [SEL_W-1:0] SEL_RESET = '1;

    typedef enum logic {
        SRC_PRESCALER = 1'b0,
        SRC_SUBCLOCK  = 1'b1
    } tick_src_e;

    typedef struct packed {
        tick_src_e        src;
        logic [SEL_W-1:0] tap_idx;
    } tick_route_t;

    // log2 of the divide ratio for each prescaler tap
    function automatic int tap_shift(input int idx);
        return (idx < NUM_TAPS - 1) ? idx + 1 : 13;
    endfunction

    localparam int PRE_W = tap_shift(NUM_TAPS - 1);

    function automatic tick_route_t decode_sel(input logic [SEL_W-1:0] sel,
                                               input logic override);
        tick_route_t r;
        r.tap_idx = sel;
        if (override || (int'(sel) >= NUM_TAPS)) r.src = SRC_SUBCLOCK;
        else                                     r.src = SRC_PRESCALER;
        return r;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int N_TAPS = NUM_TAPS,
    parameter int DIV_W  = PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [N_TAPS-1:0] tap_o
);
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int SH = tap_shift(i);
        assign tap_o[i] = &div_q[SH-1:0];

        if (i > 0) begin : g_nest
            // a slower tap only fires together with every faster one
            p_tap_nested_r6: assert property (@(posedge clk) disable iff (rst)
                tap_o[i] |-> tap_o[i-1]);
        end
    end

    p_fastest_alternates_r6: assert property (@(posedge clk) disable iff (rst)
        tap_o[0] |=> !tap_o[0]);

endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
    import wdt_pkg::*;
#(
    parameter int N_TAPS = NUM_TAPS
) (
    input  logic [N_TAPS-1:0] tap_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              override_i,
    input  logic              sub_tick_i,
    output logic              tick_o
);
    tick_route_t route;
    logic        pre_tick;

    always_comb begin
        route    = decode_sel(sel_i, override_i);
        pre_tick = 1'b0;
        for (int i = 0; i < N_TAPS; i++) begin
            if (route.tap_idx == SEL_W'(i)) pre_tick = tap_i[i];
        end
        tick_o = (route.src == SRC_SUBCLOCK) ? sub_tick_i : pre_tick;
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         clr_flag_i,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         pulse_o
);
    logic [W-1:0] cnt_q;
    logic         flag_q;
    logic         pulse_q;
    logic         wrap;

    assign wrap = tick_i && !load_i && (cnt_q == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (load_i)      cnt_q <= load_val_i;
            else if (tick_i) cnt_q <= cnt_q + 1'b1;

            if (wrap)            flag_q <= 1'b1;
            else if (clr_flag_i) flag_q <= 1'b0;

            pulse_q <= wrap;
        end
    end

    assign count_o = cnt_q;
    assign flag_o  = flag_q;
    assign pulse_o = pulse_q;

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && cnt_q != {W{1'b1}}) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(cnt_q));

    p_wrap_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && cnt_q == {W{1'b1}}) |=> (pulse_q && cnt_q == '0));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_flag_i) |=> flag_q);

    p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> flag_q);

    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i) && !pulse_q));

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    input  logic              sel_override_i,
    input  logic              sub_tick_i,
    output logic              wdt_rst_o
);
    localparam int RSV_W = CNT_W - SEL_W;

    logic [NUM_TAPS-1:0] taps;
    logic [SEL_W-1:0]    sel_q;
    logic                tick;
    logic                cnt_load;
    logic                flag_clr;
    logic [CNT_W-1:0]    count;
    logic                flag;

    assign cnt_load = we_i && (addr_i == ADDR_CNT);
    assign flag_clr = we_i && (addr_i == ADDR_STAT) && !wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst)                               sel_q <= SEL_RESET;
        else if (we_i && addr_i == ADDR_MODE)  sel_q <= wdata_i[SEL_W-1:0];
    end

    wdt_prescaler #(.N_TAPS(NUM_TAPS), .DIV_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .tap_o (taps)
    );

    wdt_tick_sel #(.N_TAPS(NUM_TAPS)) u_sel (
        .tap_i      (taps),
        .sel_i      (sel_q),
        .override_i (sel_override_i),
        .sub_tick_i (sub_tick_i),
        .tick_o     (tick)
    );

    wdt_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .load_i     (cnt_load),
        .load_val_i (wdata_i),
        .clr_flag_i (flag_clr),
        .count_o    (count),
        .flag_o     (flag),
        .pulse_o    (wdt_rst_o)
    );

    always_comb begin
        case (addr_i)
            ADDR_CNT:  rdata_o = count;
            ADDR_MODE: rdata_o = {{RSV_W{1'b1}}, sel_q};
            ADDR_STAT: rdata_o = {{(CNT_W-1){1'b0}}, flag};
            default:   rdata_o = '0;
        endcase
    end

    p_override_r8: assert property (@(posedge clk) disable iff (rst)
        sel_override_i |-> (tick == sub_tick_i));

    p_reserved_code_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(sel_q) >= NUM_TAPS) |-> (tick == sub_tick_i));

    p_mode_upper_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (addr_i == ADDR_MODE) |-> (rdata_o[CNT_W-1:SEL_W] == {RSV_W{1'b1}}));

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (sel_q == SEL_RESET && count == '0 && !flag && !wdt_rst_o));

endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr_i = 2'd0;
    logic       we_i = 1'b0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       sel_override_i = 1'b0;
    logic       sub_tick_i = 1'b0;
    logic       wdt_rst_o;

    always #4 clk = ~clk;

    wdt_top dut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .sel_override_i(sel_override_i),
        .sub_tick_i(sub_tick_i), .wdt_rst_o(wdt_rst_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    sub_en = 1'b1;

    // reference state
    int m_pre = 0, m_cnt = 0, m_mode = 15;
    bit m_flag = 0, m_pulse = 0;

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_cnt;
            1: return 8'hF0 | m_mode;
            2: return m_flag;
            default: return 0;
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        bit tick, ovf, ld, clr;
        int sh;
        cyc++;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_mode = 15; m_flag = 0; m_pulse = 0;
        end else begin
            if (sel_override_i || m_mode > 9) tick = sub_tick_i;
            else begin
                sh   = (m_mode < 9) ? m_mode + 1 : 13;
                tick = (((m_pre + 1) % (1 << sh)) == 0);
            end
            ld  = we_i && addr_i == 2'd0;
            clr = we_i && addr_i == 2'd2 && !wdata_i[0];
            ovf = tick && !ld && m_cnt == 255;
            if (ld)        m_cnt = wdata_i;
            else if (tick) m_cnt = (m_cnt + 1) % 256;
            if (ovf)       m_flag = 1;
            else if (clr)  m_flag = 0;
            m_pulse = ovf;
            if (we_i && addr_i == 2'd1) m_mode = wdata_i[3:0];
            m_pre = (m_pre + 1) % 8192;
        end
        #2;
        n_cmp++;
        if (rdata_o !== 8'(exp_rdata(addr_i))) begin
            n_bad++;
            $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h cycle=%0d",
                     cur_req, addr_i, rdata_o, 8'(exp_rdata(addr_i)), cyc);
        end
        n_cmp++;
        if (wdt_rst_o !== m_pulse) begin
            n_bad++;
            $display("FAIL %s wdt_rst_o actual=%0b expected=%0b cycle=%0d",
                     cur_req, wdt_rst_o, m_pulse, cyc);
        end
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    // subclock/32 enable stand-in: one pulse every 7 cycles
    int subc = 0;
    always @(negedge clk) begin
        subc = (subc + 1) % 7;
        sub_tick_i <= sub_en && (subc == 6);
    end

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic watch(input logic [1:0] a, input int n);
        addr_i = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset values at every address
        cur_req = "R1";
        watch(2'd1, 2); watch(2'd0, 2); watch(2'd2, 2);

        // R5: reserved bits read as ones
        cur_req = "R5";
        write_reg(2'd1, 8'h03); watch(2'd1, 3);
        write_reg(2'd1, 8'hA5); watch(2'd1, 3);

        // R6 and R2: each prescaler code
        cur_req = "R6";
        for (int c = 0; c < 10; c++) begin
            write_reg(2'd1, 8'(c));
            write_reg(2'd0, 8'h00);
            if (c == 9) watch(2'd0, 17000);
            else        watch(2'd0, (4 << (c + 1)) + 5);
        end
        cur_req = "R2";
        write_reg(2'd1, 8'h02); write_reg(2'd0, 8'h40); watch(2'd0, 60);

        // R7: reserved codes use the subclock tick
        cur_req = "R7";
        write_reg(2'd1, 8'h0C); write_reg(2'd0, 8'h00); watch(2'd0, 80);
        write_reg(2'd1, 8'h0F); watch(2'd0, 40);

        // R8: override
        cur_req = "R8";
        write_reg(2'd1, 8'h00);
        sel_override_i = 1'b1; watch(2'd0, 80);
        sel_override_i = 1'b0; watch(2'd0, 20);

        // R3: rollover by ticking from near the top
        cur_req = "R3";
        write_reg(2'd0, 8'hF8); watch(2'd0, 30);
        watch(2'd2, 2);

        // R4: sticky flag, write-1 ignored, clear, collision with rollover
        cur_req = "R4";
        write_reg(2'd2, 8'h01); watch(2'd2, 4);
        write_reg(2'd2, 8'h00); watch(2'd2, 4);
        write_reg(2'd0, 8'hF0);
        @(negedge clk);
        addr_i = 2'd2; wdata_i = 8'h00; we_i = 1'b1;
        repeat (40) @(negedge clk);
        we_i = 1'b0;
        watch(2'd2, 4);
        write_reg(2'd1, 8'h05); write_reg(2'd0, 8'hFF);
        @(negedge clk);
        addr_i = 2'd2; wdata_i = 8'h00; we_i = 1'b1;
        repeat (70) @(negedge clk);
        we_i = 1'b0;
        watch(2'd2, 4);

        // R9: repeated loads of 0xFF and 0x00 never pulse
        cur_req = "R9";
        write_reg(2'd1, 8'h00); write_reg(2'd2, 8'h00);
        @(negedge clk);
        addr_i = 2'd0; wdata_i = 8'hFF; we_i = 1'b1;
        repeat (12) @(negedge clk);
        wdata_i = 8'h00;
        repeat (3) @(negedge clk);
        we_i = 1'b0;
        watch(2'd2, 3); watch(2'd0, 6);

        // R10: unused address reads zero
        cur_req = "R10";
        watch(2'd3, 4);

        // R1: reset again mid-run
        cur_req = "R1";
        write_reg(2'd0, 8'h77);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        watch(2'd0, 2); watch(2'd1, 2); watch(2'd2, 2);

        summary();
        $finish;
    end
endmodule